// File: doc/BRIEF.md
# Frame-Size-Dependent Transmit/Receive Word FIFO Pair

This block holds the two word queues of a serial controller: one carries words from the register side towards the shift engine (transmit), the other carries received words back (receive). Each queue has 32 physical storage entries. The number of entries it will actually accept is a run-time setting. With the large-queue mode off, each queue takes four words. With it on, the limit follows the programmed frame width, so narrow frames get a deep queue and wide frames a shallow one.

The register side and the transfer engine drive push and pop strobes. The read side is show-ahead: while a queue holds data, its oldest word is already on the pop-data output, and a pop strobe only moves past it. Each queue reports empty, full and almost-full (one free slot left) and has its own synchronous flush. The limit is latched only when the control word is written. Changing it never moves or drops words that are already stored.

Top module: `flex_fifo_pair`

## Requirements
- R1: After a control write with the large-queue mode (`cfgBigMode`) at 0, both queues accept exactly 4 words, whatever the frame size.
- R2: After a control write with `cfgBigMode` at 1, the limit is taken from the 6-bit `cfgFrameSize`: 32 words for sizes 0 to 8, 16 words for sizes 9 to 16, and 8 words for sizes 17 and above.
- R3: A push to a queue whose occupancy has reached the limit is dropped. The stored words and the occupancy are left as they were.
- R4: `AlmostFull` is 1 exactly when occupancy equals the limit minus one. `Full` is 1 when occupancy is at or above the limit.
- R5: A flush empties only its own queue on the next clock edge. Empty then reads 1 and full reads 0, and a push in the same cycle as the flush is discarded.
- R6: While a queue is empty its pop-data output reads 0, and a pop strobe changes nothing. A later push/pop pair returns the pushed word.
- R7: After reset, both queues are empty and not full, and the limit is 4.
- R8: Empty reads 1 right after the clock edge at which the pop removing the last word is taken.
- R9: The limit changes only on a clock edge with `cfgWrite` high. Words already stored stay and drain in order even when the new limit is below the occupancy.
- R10: Words leave each queue in push order, with the oldest shown on pop data. A push and a pop in the same cycle on a non-full, non-empty queue leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrite | input | 1 | Control word write strobe; latches the limit |
| cfgBigMode | input | 1 | Large-queue mode select |
| cfgFrameSize | input | 6 | Programmed frame width in bits |
| txPush | input | 1 | Transmit queue push strobe |
| txPushData | input | 32 | Word to push into the transmit queue |
| txPop | input | 1 | Transmit queue pop strobe |
| txFlush | input | 1 | Transmit queue synchronous flush |
| txPopData | output | 32 | Oldest transmit word, 0 when empty |
| txEmpty | output | 1 | Transmit queue empty |
| txFull | output | 1 | Transmit queue at limit |
| txAlmostFull | output | 1 | Transmit queue one slot below limit |
| rxPush | input | 1 | Receive queue push strobe |
| rxPushData | input | 32 | Word to push into the receive queue |
| rxPop | input | 1 | Receive queue pop strobe |
| rxFlush | input | 1 | Receive queue synchronous flush |
| rxPopData | output | 32 | Oldest receive word, 0 when empty |
| rxEmpty | output | 1 | Receive queue empty |
| rxFull | output | 1 | Receive queue at limit |
| rxAlmostFull | output | 1 | Receive queue one slot below limit |

## Verification
The in-module properties check on every cycle the parts that are local in time. A dropped push at the limit leaves the occupancy alone. A flush always lands on empty. A pop on an empty queue moves no pointer. The occupancy never steps by more than one. The limit is always one of the four legal values and holds between control writes. Empty pop data is zero.

Only the bench scenarios can show the actual limit for each frame-size band, the word order across a full fill and drain, the flags at each occupancy, and that a dropped word never shows up later. They also show that lowering the limit below the occupancy keeps the stored words intact, and that flushing one queue leaves the other untouched.

// File: rtl/flex_fifo_pkg.sv
package flex_fifo_pkg;
  localparam int unsigned ENTRIES    = 32;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned SIZE_W     = 6;
  localparam int unsigned PTR_W      = $clog2(ENTRIES);
  localparam int unsigned CNT_W      = PTR_W + 1;
  localparam int unsigned CHANNELS   = 2;

  typedef struct packed {
    logic             wrEn;
    logic [PTR_W-1:0] wrAddr;
    logic [PTR_W-1:0] rdAddr;
    logic             rdValid;
  } storeCtl_t;
endpackage

// File: rtl/flex_depth_select.sv
module flex_depth_select
  import flex_fifo_pkg::*;
#(
  parameter int unsigned SMALL_DEPTH = 4,
  parameter int unsigned NARROW_MAX  = 8,
  parameter int unsigned MID_MAX     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrite,
  input  logic              cfgBigMode,
  input  logic [SIZE_W-1:0] cfgFrameSize,
  output logic [CNT_W-1:0]  depth
);
  localparam logic [CNT_W-1:0] DEPTH_SMALL  = CNT_W'(SMALL_DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_NARROW = CNT_W'(ENTRIES);
  localparam logic [CNT_W-1:0] DEPTH_MID    = CNT_W'(ENTRIES / 2);
  localparam logic [CNT_W-1:0] DEPTH_WIDE   = CNT_W'(ENTRIES / 4);

  logic [CNT_W-1:0] nextDepth;

  always_comb begin
    if (!cfgBigMode)                            nextDepth = DEPTH_SMALL;
    else if (cfgFrameSize <= SIZE_W'(NARROW_MAX)) nextDepth = DEPTH_NARROW;
    else if (cfgFrameSize <= SIZE_W'(MID_MAX))    nextDepth = DEPTH_MID;
    else                                        nextDepth = DEPTH_WIDE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        depth <= DEPTH_SMALL;
    else if (cfgWrite) depth <= nextDepth;
  end

  assert_depth_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgWrite |=> $stable(depth));
  assert_depth_small_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrite && !cfgBigMode) |=> depth == DEPTH_SMALL);
  assert_depth_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(depth) == 1 && depth >= DEPTH_SMALL);
endmodule

// File: rtl/flex_fifo_ctrl.sv
module flex_fifo_ctrl
  import flex_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] depth,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output storeCtl_t        ctl,
  output logic             empty,
  output logic             full,
  output logic             almostFull
);
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             pushOk, popOk;

  assign pushOk = push && !flush && (count < depth);
  assign popOk  = pop  && !flush && (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + 1'b1;
      if (popOk)  rdPtr <= rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign empty      = (count == '0);
  assign full       = (count >= depth);
  assign almostFull = (count == depth - 1'b1);

  assign ctl.wrEn    = pushOk;
  assign ctl.wrAddr  = wrPtr;
  assign ctl.rdAddr  = rdPtr;
  assign ctl.rdValid = !empty;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> $stable(count));
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !full));
  assert_empty_pop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> ($stable(rdPtr) && $stable(wrPtr)));
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flush) |-> (count == $past(count) || count == $past(count) + 1'b1
                       || count == $past(count) - 1'b1));
endmodule

// File: rtl/flex_fifo_store.sv
module flex_fifo_store
  import flex_fifo_pkg::*;
(
  input  logic              clk,
  input  storeCtl_t         ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (ctl.wrEn) mem[ctl.wrAddr] <= wrData;
  end

  assign rdData = ctl.rdValid ? mem[ctl.rdAddr] : '0;
endmodule

// File: rtl/flex_fifo_pair.sv
module flex_fifo_pair
  import flex_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrite,
  input  logic              cfgBigMode,
  input  logic [SIZE_W-1:0] cfgFrameSize,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txPushData,
  input  logic              txPop,
  input  logic              txFlush,
  output logic [DATA_W-1:0] txPopData,
  output logic              txEmpty,
  output logic              txFull,
  output logic              txAlmostFull,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic              rxPop,
  input  logic              rxFlush,
  output logic [DATA_W-1:0] rxPopData,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic              rxAlmostFull
);
  logic [CNT_W-1:0]  depth;
  logic              chPush   [CHANNELS];
  logic              chPop    [CHANNELS];
  logic              chFlush  [CHANNELS];
  logic [DATA_W-1:0] chWrData [CHANNELS];
  logic [DATA_W-1:0] chRdData [CHANNELS];
  logic              chEmpty  [CHANNELS];
  logic              chFull   [CHANNELS];
  logic              chAlmost [CHANNELS];

  assign chPush[0] = txPush;  assign chPop[0] = txPop;
  assign chFlush[0] = txFlush; assign chWrData[0] = txPushData;
  assign chPush[1] = rxPush;  assign chPop[1] = rxPop;
  assign chFlush[1] = rxFlush; assign chWrData[1] = rxPushData;

  assign txPopData = chRdData[0]; assign txEmpty = chEmpty[0];
  assign txFull = chFull[0];      assign txAlmostFull = chAlmost[0];
  assign rxPopData = chRdData[1]; assign rxEmpty = chEmpty[1];
  assign rxFull = chFull[1];      assign rxAlmostFull = chAlmost[1];

  flex_depth_select i_depth (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .cfgBigMode(cfgBigMode),
    .cfgFrameSize(cfgFrameSize), .depth(depth)
  );

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    storeCtl_t ctl;

    flex_fifo_ctrl i_ctrl (
      .clk(clk), .rst_n(rst_n), .depth(depth), .push(chPush[ch]),
      .pop(chPop[ch]), .flush(chFlush[ch]), .ctl(ctl),
      .empty(chEmpty[ch]), .full(chFull[ch]), .almostFull(chAlmost[ch])
    );

    flex_fifo_store i_store (
      .clk(clk), .ctl(ctl), .wrData(chWrData[ch]), .rdData(chRdData[ch])
    );

    assert_empty_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chEmpty[ch] |-> chRdData[ch] == '0);
  end
endmodule

// File: tb/test_flex_fifo_pair.sv
module test_flex_fifo_pair;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWrite = 1'b0, cfgBigMode = 1'b0;
  logic [5:0] cfgFrameSize = 6'd4;
  logic        push [2];
  logic        pop  [2];
  logic        flush[2];
  logic [31:0] wdat [2];
  logic [31:0] rdat [2];
  logic        empty[2], full[2], almost[2];
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flex_fifo_pair i_flex_fifo_pair (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .cfgBigMode(cfgBigMode),
    .cfgFrameSize(cfgFrameSize),
    .txPush(push[0]), .txPushData(wdat[0]), .txPop(pop[0]), .txFlush(flush[0]),
    .txPopData(rdat[0]), .txEmpty(empty[0]), .txFull(full[0]), .txAlmostFull(almost[0]),
    .rxPush(push[1]), .rxPushData(wdat[1]), .rxPop(pop[1]), .rxFlush(flush[1]),
    .rxPopData(rdat[1]), .rxEmpty(empty[1]), .rxFull(full[1]), .rxAlmostFull(almost[1])
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doPush(int ch, logic [31:0] d);
    push[ch] = 1'b1; wdat[ch] = d;
    tick();
    push[ch] = 1'b0;
  endtask

  task automatic doPop(int ch);
    pop[ch] = 1'b1;
    tick();
    pop[ch] = 1'b0;
  endtask

  task automatic writeCfg(logic big, logic [5:0] fs);
    cfgBigMode = big; cfgFrameSize = fs; cfgWrite = 1'b1;
    tick();
    cfgWrite = 1'b0;
  endtask

  // Fill to the limit, test flags and drop, then drain in order.
  task automatic verifyDepth(int ch, int expDepth, string req);
    logic [31:0] base = 32'h1000_0000 * (ch + 1) + (expDepth << 16);
    for (int k = 0; k < expDepth; k++) begin
      doPush(ch, base + k);
      check("R4 almostFull", 32'(almost[ch]), 32'(k + 1 == expDepth - 1));
      check({req, " full"}, 32'(full[ch]), 32'(k + 1 == expDepth));
    end
    doPush(ch, 32'hDEAD_BEEF);
    check("R3 full after drop", 32'(full[ch]), 32'd1);
    for (int k = 0; k < expDepth; k++) begin
      check("R10 order / R3 no dropped word", rdat[ch], base + k);
      doPop(ch);
    end
    check("R8 empty after last pop", 32'(empty[ch]), 32'd1);
    check("R6 empty reads zero", rdat[ch], 32'd0);
  endtask

  task automatic testReset();
    check("R7 tx empty", 32'(empty[0]), 32'd1);
    check("R7 rx empty", 32'(empty[1]), 32'd1);
    check("R7 tx not full", 32'(full[0]), 32'd0);
    check("R7 rx not full", 32'(full[1]), 32'd0);
    verifyDepth(0, 4, "R7 reset depth");
    verifyDepth(1, 4, "R7 reset depth");
  endtask

  task automatic testBands();
    writeCfg(1'b1, 6'd8);  verifyDepth(0, 32, "R2 size8");
    writeCfg(1'b1, 6'd0);  verifyDepth(1, 32, "R2 size0");
    writeCfg(1'b1, 6'd9);  verifyDepth(1, 16, "R2 size9");
    writeCfg(1'b1, 6'd16); verifyDepth(0, 16, "R2 size16");
    writeCfg(1'b1, 6'd17); verifyDepth(0, 8, "R2 size17");
    writeCfg(1'b1, 6'd32); verifyDepth(1, 8, "R2 size32");
    writeCfg(1'b0, 6'd8);  verifyDepth(0, 4, "R1 off size8");
    writeCfg(1'b0, 6'd32); verifyDepth(1, 4, "R1 off size32");
  endtask

  task automatic testHold();
    writeCfg(1'b1, 6'd8);
    cfgBigMode = 1'b0; cfgFrameSize = 6'd20;
    tick();
    verifyDepth(0, 32, "R9 no strobe");
    writeCfg(1'b1, 6'd12);
    for (int k = 0; k < 10; k++) doPush(0, 32'hA000 + k);
    writeCfg(1'b0, 6'd12);
    check("R9 full above new limit", 32'(full[0]), 32'd1);
    doPush(0, 32'hBAD0);
    for (int k = 0; k < 10; k++) begin
      check("R9 stored word kept", rdat[0], 32'hA000 + k);
      doPop(0);
    end
    check("R9 drained", 32'(empty[0]), 32'd1);
  endtask

  task automatic testFlush();
    for (int k = 0; k < 3; k++) begin
      push[0] = 1'b1; wdat[0] = 32'hF000 + k;
      push[1] = 1'b1; wdat[1] = 32'hE000 + k;
      tick();
    end
    push[0] = 1'b0; push[1] = 1'b0;
    flush[0] = 1'b1; push[0] = 1'b1; wdat[0] = 32'h1234;
    tick();
    flush[0] = 1'b0; push[0] = 1'b0;
    check("R5 tx empty", 32'(empty[0]), 32'd1);
    check("R5 tx not full", 32'(full[0]), 32'd0);
    check("R5 tx reads zero", rdat[0], 32'd0);
    check("R5 rx untouched", rdat[1], 32'hE000);
    check("R5 rx almostFull", 32'(almost[1]), 32'd1);
    flush[1] = 1'b1;
    tick();
    flush[1] = 1'b0;
    check("R5 rx empty", 32'(empty[1]), 32'd1);
  endtask

  task automatic testEmptyPop();
    doPop(1);
    check("R6 still empty", 32'(empty[1]), 32'd1);
    check("R6 pop data zero", rdat[1], 32'd0);
    doPush(1, 32'h5A5A_0001);
    check("R6 next word", rdat[1], 32'h5A5A_0001);
    doPop(1);
    check("R8 empty after pop", 32'(empty[1]), 32'd1);
  endtask

  task automatic testPushPop();
    for (int k = 0; k < 3; k++) doPush(1, 32'hC000 + k);
    push[1] = 1'b1; wdat[1] = 32'hC003; pop[1] = 1'b1;
    tick();
    push[1] = 1'b0; pop[1] = 1'b0;
    check("R10 almostFull kept", 32'(almost[1]), 32'd1);
    check("R10 not full", 32'(full[1]), 32'd0);
    for (int k = 1; k < 4; k++) begin
      check("R10 order", rdat[1], 32'hC000 + k);
      doPop(1);
    end
    check("R10 empty", 32'(empty[1]), 32'd1);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      push[c] = 1'b0; pop[c] = 1'b0; flush[c] = 1'b0; wdat[c] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    testReset();
    testBands();
    testHold();
    testFlush();
    testEmptyPop();
    testPushPop();
    finishRun();
  end
endmodule